// File: doc/BRIEF.md
# Asynchronous DRAM Strobe Command Decoder

This block sits on the device side of an asynchronous DRAM and works out which cycle the host is running. It looks only at the order in which the row strobe, column strobe, write enable and output enable change. It does not use a command opcode. The four active-low strobes and the multiplexed address bus are sampled by a fast local clock through a two-stage synchronizer. A state machine then reads the synchronized samples and, at the sample where a cycle is recognised, emits a one-clock classification pulse. The pulse carries a 4-bit cycle code and updates the latched row address, column address and refresh row.

The block also holds the internal refresh row counter used by refresh cycles in which the column strobe falls first. It decides whether the data bus should be driven. Read data is driven while output enable is asserted. Writes and refreshes leave the bus undriven. A hidden refresh keeps the earlier read data on the bus. The memory array is not part of the block.

State machine. The states are IDLE (both strobes high), ROW (row open, column strobe high), COL (column strobe low inside a row), HOLDCAS (row strobe high while the column strobe is still held low after an access), CBR_ARM (column strobe low with the row strobe high) and REFRESH (row strobe low in a counter refresh). The transitions are:
- IDLE to ROW on a row fall.
- IDLE to COL on a simultaneous fall.
- IDLE to CBR_ARM on a column fall.
- ROW to COL on a column fall.
- ROW to IDLE on a row rise.
- COL to ROW on a column rise, which marks the next access as a page access.
- COL to HOLDCAS on a row rise with the column strobe low.
- COL to IDLE on a row rise with the column strobe high.
- HOLDCAS to REFRESH on a row fall, which is a hidden refresh.
- HOLDCAS to IDLE on a column rise.
- CBR_ARM to REFRESH on a row fall.
- CBR_ARM to IDLE on a column rise.
- REFRESH to CBR_ARM or IDLE on a row rise, depending on the column strobe.

Top module: `dram_strobe_decoder`

## Requirements
- R1: A strobe change reaches the outputs three clock edges after the pin changes: two synchronizer stages, then one output register. The classification pulse `cyc_valid` lasts one clock per recognised cycle.
- R2: A column fall inside an open row with write enable high is a read, code 1. The row and column addresses are latched from the address present at the row fall and at the column fall. `dq_oe` is high while the column strobe and output enable are low.
- R3: Write enable low at the column fall is an early write, code 2, and `dq_oe` stays low throughout.
- R4: Write enable falling after a read column fall, with the column strobe still low, is a read-modify-write, code 3, and `dq_oe` drops at that point.
- R5: A column fall that follows a column rise inside the same row is a page access: page read is code 4, page early write is code 5 and page read-modify-write is code 6.
- R6: A row fall and rise with no column fall in between is a row-only refresh, code 7. `ref_row` takes the low REF_W bits of the latched row address.
- R7: A column fall before a row fall, with write enable high, is a counter refresh, code 8. `ref_row` shows the counter, and the counter then advances by one. It wraps modulo 2^REF_W (4096 rows by default).
- R8: Write enable low at the row fall of a column-first sequence is test-mode entry, code 11. The refresh counter does not advance.
- R9: When the column strobe stays low after an access while the row strobe rises and falls again, the cycle is a hidden refresh, code 9. It uses and advances the counter, and `dq_oe` keeps driving the earlier read data.
- R10: When the row strobe stays low in a counter or hidden refresh for SELF_CYC clocks (100 us at 200 MHz by default), one self-refresh event, code 10, is emitted. A shorter hold emits none.
- R11: Row and column strobes falling in the same sample are resolved as row first, so the cycle is an access and not a refresh.
- R12: `dq_oe` is low during row-only, counter, self-refresh and test-mode cycles, even with output enable asserted.
- R13: `cyc_type` is 0 whenever `cyc_valid` is low, and is a defined code (1 to 11) whenever it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Multiplexed row/column address |
| cyc_valid | output | 1 | One-clock classification pulse |
| cyc_type | output | 4 | Cycle code, 0 when no pulse |
| row_addr | output | ADDR_W | Latched row address |
| col_addr | output | ADDR_W | Latched column address |
| ref_row | output | REF_W | Row refreshed by the last refresh cycle |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The decoder is driven with strobe orderings that differ only in which edge comes first, and each pattern separates a pair of cycle types:
- Column fall with write enable high versus low separates a read from an early write.
- Write enable falling later separates a read-modify-write from a read.
- A second column fall inside one row separates page codes from first-access codes.
- Column-first versus row-first separates a counter refresh from an access.
- A same-sample fall checks the row-first tie rule.
- Write enable at the column-first row fall separates test entry from refresh.
- Holding the column strobe across a row precharge separates hidden refresh from a fresh counter refresh.
A reference counter in the bench follows every refresh row through a full wrap of the counter. A long row hold separates self-refresh from a plain counter refresh.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    typedef enum logic [3:0] {
        CYC_NONE    = 4'd0,
        CYC_READ    = 4'd1,
        CYC_EWR     = 4'd2,
        CYC_RMW     = 4'd3,
        CYC_PG_READ = 4'd4,
        CYC_PG_EWR  = 4'd5,
        CYC_PG_RMW  = 4'd6,
        CYC_ROR     = 4'd7,
        CYC_CBR     = 4'd8,
        CYC_HIDDEN  = 4'd9,
        CYC_SELF    = 4'd10,
        CYC_TEST    = 4'd11
    } cyc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_HOLDCAS,
        ST_CBR_ARM,
        ST_REFRESH
    } st_e;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/ref_row_ctr.sv
module ref_row_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (inc) begin
            q <= q + W'(1);
        end
    end

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int LIMIT = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic hit
);

    localparam int            TW   = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && cnt != LAST) begin
            cnt <= cnt + TW'(1);
        end
    end

    assign hit = en && (cnt == LAST);

endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
    import dsd_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int REF_W    = 12,
    parameter int SYNC_STG = 2,
    parameter int SELF_CYC = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              cyc_valid,
    output logic [3:0]        cyc_type,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic [REF_W-1:0]  ref_row,
    output logic              dq_oe
);

    localparam int NSTB = 4;

    // synchronized strobes (active low) and address
    logic [NSTB-1:0]   s_n;
    logic [ADDR_W-1:0] a_s;

    strobe_sync #(.W(NSTB), .STAGES(SYNC_STG), .RST_VAL({NSTB{1'b1}})) u_sync_stb (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ras_n, cas_n, we_n, oe_n}),
        .q     (s_n)
    );

    strobe_sync #(.W(ADDR_W), .STAGES(SYNC_STG), .RST_VAL('0)) u_sync_adr (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (addr),
        .q     (a_s)
    );

    logic ras, cas, we, oe;
    assign ras = ~s_n[3];
    assign cas = ~s_n[2];
    assign we  = ~s_n[1];
    assign oe  = ~s_n[0];

    // state and flags
    st_e               st, st_nx;
    logic              rd_q, page_q, wr_q, sd_q, we_q;
    logic [ADDR_W-1:0] row_q, col_q;
    logic [REF_W-1:0]  ref_q;
    logic              valid_q;
    cyc_e              type_q;

    // decisions of the current sample
    logic ev;
    cyc_e ev_t;
    logic lat_row, lat_col, ref_cnt, ref_row_src, cnt_inc, tmr_clr;
    logic set_rd, clr_rd, set_page, clr_page, set_wr, clr_wr, set_sd, clr_sd;

    logic [REF_W-1:0] cnt_q;
    logic             tmr_hit;

    ref_row_ctr #(.W(REF_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cnt_inc),
        .q     (cnt_q)
    );

    hold_timer #(.LIMIT(SELF_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .en    (st == ST_REFRESH),
        .hit   (tmr_hit)
    );

    // next state and cycle classification
    always_comb begin
        st_nx       = st;
        ev          = 1'b0;
        ev_t        = CYC_NONE;
        lat_row     = 1'b0;
        lat_col     = 1'b0;
        ref_cnt     = 1'b0;
        ref_row_src = 1'b0;
        cnt_inc     = 1'b0;
        tmr_clr     = 1'b0;
        set_rd      = 1'b0;
        clr_rd      = 1'b0;
        set_page    = 1'b0;
        clr_page    = 1'b0;
        set_wr      = 1'b0;
        clr_wr      = 1'b0;
        set_sd      = 1'b0;
        clr_sd      = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (ras) begin
                    lat_row  = 1'b1;
                    clr_page = 1'b1;
                    if (cas) begin
                        // same-sample fall: row first, then the column
                        lat_col = 1'b1;
                        ev      = 1'b1;
                        ev_t    = we ? CYC_EWR : CYC_READ;
                        set_wr  = we;
                        clr_wr  = ~we;
                        set_rd  = ~we;
                        clr_rd  = we;
                        st_nx   = ST_COL;
                    end else begin
                        st_nx = ST_ROW;
                    end
                end else if (cas) begin
                    st_nx = ST_CBR_ARM;
                end
            end
            ST_ROW: begin
                if (!ras) begin
                    if (!page_q) begin
                        ev          = 1'b1;
                        ev_t        = CYC_ROR;
                        ref_row_src = 1'b1;
                    end
                    clr_rd = 1'b1;
                    st_nx  = ST_IDLE;
                end else if (cas) begin
                    lat_col = 1'b1;
                    ev      = 1'b1;
                    if (we) begin
                        ev_t = page_q ? CYC_PG_EWR : CYC_EWR;
                    end else begin
                        ev_t = page_q ? CYC_PG_READ : CYC_READ;
                    end
                    set_wr = we;
                    clr_wr = ~we;
                    set_rd = ~we;
                    clr_rd = we;
                    st_nx  = ST_COL;
                end
            end
            ST_COL: begin
                if (!ras) begin
                    if (cas) begin
                        st_nx = ST_HOLDCAS;
                    end else begin
                        clr_rd = 1'b1;
                        st_nx  = ST_IDLE;
                    end
                end else if (!cas) begin
                    clr_rd   = 1'b1;
                    set_page = 1'b1;
                    st_nx    = ST_ROW;
                end else if (we && !we_q && !wr_q) begin
                    ev     = 1'b1;
                    ev_t   = page_q ? CYC_PG_RMW : CYC_RMW;
                    set_wr = 1'b1;
                    clr_rd = 1'b1;
                end
            end
            ST_HOLDCAS: begin
                if (!cas) begin
                    clr_rd = 1'b1;
                    st_nx  = ST_IDLE;
                end else if (ras) begin
                    ev      = 1'b1;
                    ev_t    = CYC_HIDDEN;
                    ref_cnt = 1'b1;
                    cnt_inc = 1'b1;
                    tmr_clr = 1'b1;
                    clr_sd  = 1'b1;
                    st_nx   = ST_REFRESH;
                end
            end
            ST_CBR_ARM: begin
                if (!cas) begin
                    clr_rd = 1'b1;
                    st_nx  = ST_IDLE;
                end else if (ras) begin
                    ev      = 1'b1;
                    clr_rd  = 1'b1;
                    tmr_clr = 1'b1;
                    if (we) begin
                        ev_t   = CYC_TEST;
                        set_sd = 1'b1;
                    end else begin
                        ev_t    = CYC_CBR;
                        ref_cnt = 1'b1;
                        cnt_inc = 1'b1;
                        clr_sd  = 1'b1;
                    end
                    st_nx = ST_REFRESH;
                end
            end
            ST_REFRESH: begin
                if (!ras) begin
                    if (cas) begin
                        st_nx = ST_CBR_ARM;
                    end else begin
                        clr_rd = 1'b1;
                        st_nx  = ST_IDLE;
                    end
                end else if (tmr_hit && !sd_q) begin
                    ev     = 1'b1;
                    ev_t   = CYC_SELF;
                    clr_rd = 1'b1;
                    set_sd = 1'b1;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // outputs and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            type_q  <= CYC_NONE;
            row_q   <= '0;
            col_q   <= '0;
            ref_q   <= '0;
            rd_q    <= 1'b0;
            page_q  <= 1'b0;
            wr_q    <= 1'b0;
            sd_q    <= 1'b0;
            we_q    <= 1'b0;
        end else begin
            valid_q <= ev;
            type_q  <= ev ? ev_t : CYC_NONE;
            we_q    <= we;
            if (lat_row) row_q <= a_s;
            if (lat_col) col_q <= a_s;
            if (ref_cnt) begin
                ref_q <= cnt_q;
            end else if (ref_row_src) begin
                ref_q <= row_q[REF_W-1:0];
            end
            if (set_rd) begin
                rd_q <= 1'b1;
            end else if (clr_rd) begin
                rd_q <= 1'b0;
            end
            if (set_page) begin
                page_q <= 1'b1;
            end else if (clr_page) begin
                page_q <= 1'b0;
            end
            if (set_wr) begin
                wr_q <= 1'b1;
            end else if (clr_wr) begin
                wr_q <= 1'b0;
            end
            if (set_sd) begin
                sd_q <= 1'b1;
            end else if (clr_sd) begin
                sd_q <= 1'b0;
            end
        end
    end

    assign cyc_valid = valid_q;
    assign cyc_type  = type_q;
    assign row_addr  = row_q;
    assign col_addr  = col_q;
    assign ref_row   = ref_q;
    assign dq_oe     = rd_q & oe;

endmodule

// File: rtl/dram_strobe_decoder_chk.sv
module dram_strobe_decoder_chk
    import dsd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int REF_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_valid,
    input logic [3:0]        cyc_type,
    input logic [ADDR_W-1:0] row_addr,
    input logic [REF_W-1:0]  ref_row,
    input logic              dq_oe
);

    logic [REF_W-1:0] exp_ref;
    logic             is_cnt_ref;

    assign is_cnt_ref = cyc_valid && (cyc_type == CYC_CBR || cyc_type == CYC_HIDDEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_ref <= '0;
        end else if (is_cnt_ref) begin
            exp_ref <= exp_ref + REF_W'(1);
        end
    end

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |-> cyc_type == CYC_NONE); // R13

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> (cyc_type >= 4'd1 && cyc_type <= 4'd11)); // R13

    AST_EWR_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid && (cyc_type == CYC_EWR || cyc_type == CYC_PG_EWR) |-> !dq_oe); // R3

    AST_RMW_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid && (cyc_type == CYC_RMW || cyc_type == CYC_PG_RMW) |-> !dq_oe); // R4

    AST_ROR_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid && cyc_type == CYC_ROR |-> ref_row == row_addr[REF_W-1:0]); // R6

    AST_REF_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        is_cnt_ref |-> ref_row == exp_ref); // R7

    AST_REF_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid && (cyc_type == CYC_ROR || cyc_type == CYC_CBR ||
                      cyc_type == CYC_SELF || cyc_type == CYC_TEST) |-> !dq_oe); // R12

endmodule

bind dram_strobe_decoder dram_strobe_decoder_chk #(.ADDR_W(ADDR_W), .REF_W(REF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_valid (cyc_valid),
    .cyc_type  (cyc_type),
    .row_addr  (row_addr),
    .ref_row   (ref_row),
    .dq_oe     (dq_oe)
);

// File: tb/tb_dram_strobe_decoder.sv
`timescale 1ns/1ps
module tb_dram_strobe_decoder;

    localparam int ADDR_W   = 13;
    localparam int REF_W    = 12;
    localparam int SELF_CYC = 20000;
    localparam int NROWS    = 1 << REF_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              cyc_valid;
    logic [3:0]        cyc_type;
    logic [ADDR_W-1:0] row_addr, col_addr;
    logic [REF_W-1:0]  ref_row;
    logic              dq_oe;

    always #2.5 clk = ~clk;

    dram_strobe_decoder #(.ADDR_W(ADDR_W), .REF_W(REF_W), .SELF_CYC(SELF_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .cyc_valid(cyc_valid), .cyc_type(cyc_type), .row_addr(row_addr),
        .col_addr(col_addr), .ref_row(ref_row), .dq_oe(dq_oe)
    );

    int n_chk = 0, n_fail = 0;
    int idle_bad = 0;
    int model_cnt = 0;
    bit done = 0;
    int got_t[$], got_row[$], got_col[$], got_ref[$];

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: event capture plus reference refresh counter, every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cyc_valid && cyc_type != 4'd0) idle_bad++;
            if (cyc_valid) begin
                got_t.push_back(int'(cyc_type));
                got_row.push_back(int'(row_addr));
                got_col.push_back(int'(col_addr));
                got_ref.push_back(int'(ref_row));
                if (cyc_type == 4'd8 || cyc_type == 4'd9) begin
                    chk("R7 counter row", int'(ref_row), model_cnt % NROWS);
                    model_cnt++;
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_ev();
        got_t.delete(); got_row.delete(); got_col.delete(); got_ref.delete();
    endtask

    task automatic exp_ev(input string req, input int idx, input int t,
                          input int row, input int col, input int rf);
        if (idx >= got_t.size()) begin
            chk({req, " event missing"}, got_t.size(), idx + 1);
        end else begin
            chk({req, " type"}, got_t[idx], t);
            if (row >= 0) chk({req, " row"}, got_row[idx], row);
            if (col >= 0) chk({req, " col"}, got_col[idx], col);
            if (rf >= 0)  chk({req, " ref"}, got_ref[idx], rf);
        end
    endtask

    task automatic cbr_quick(input bit wr);
        we_n = ~wr; cas_n = 1'b0; step(3);
        ras_n = 1'b0; step(4);
        ras_n = 1'b1; step(1);
        cas_n = 1'b1; we_n = 1'b1; step(4);
    endtask

    initial begin
        step(5);
        rst_n = 1'b1;
        step(3);
        // reset state
        chk("R13 reset valid", int'(cyc_valid), 0);
        chk("R12 reset dq_oe", int'(dq_oe), 0);
        chk("R7 reset ref_row", int'(ref_row), 0);
        oe_n = 1'b0;

        // R2 read
        clear_ev();
        addr = 13'h01A5; ras_n = 1'b0; step(4);
        addr = 13'h0033; cas_n = 1'b0; step(6);
        chk("R2 read drives", int'(dq_oe), 1);
        cas_n = 1'b1; step(5);
        chk("R2 released after column rise", int'(dq_oe), 0);
        ras_n = 1'b1; step(6);
        chk("R2 count", got_t.size(), 1);
        exp_ev("R2", 0, 1, 'h1A5, 'h033, -1);

        // R3 early write
        clear_ev();
        addr = 13'h0ABC; ras_n = 1'b0; step(4);
        addr = 13'h0011; we_n = 1'b0; step(1); cas_n = 1'b0; step(6);
        chk("R3 no drive", int'(dq_oe), 0);
        cas_n = 1'b1; we_n = 1'b1; step(3); ras_n = 1'b1; step(6);
        chk("R3 count", got_t.size(), 1);
        exp_ev("R3", 0, 2, 'hABC, 'h011, -1);

        // R4 read-modify-write
        clear_ev();
        addr = 13'h0100; ras_n = 1'b0; step(4);
        addr = 13'h0022; cas_n = 1'b0; step(6);
        chk("R4 drive before write", int'(dq_oe), 1);
        we_n = 1'b0; step(6);
        chk("R4 released at write", int'(dq_oe), 0);
        cas_n = 1'b1; we_n = 1'b1; step(3); ras_n = 1'b1; step(6);
        chk("R4 count", got_t.size(), 2);
        exp_ev("R4 read part", 0, 1, 'h100, 'h022, -1);
        exp_ev("R4", 1, 3, 'h100, 'h022, -1);

        // R5 page accesses
        clear_ev();
        addr = 13'h0777; ras_n = 1'b0; step(4);
        addr = 13'h0001; cas_n = 1'b0; step(5); cas_n = 1'b1; step(4);
        addr = 13'h0002; we_n = 1'b0; step(1); cas_n = 1'b0; step(5);
        cas_n = 1'b1; we_n = 1'b1; step(4);
        addr = 13'h0003; cas_n = 1'b0; step(5);
        we_n = 1'b0; step(5);
        cas_n = 1'b1; we_n = 1'b1; step(3); ras_n = 1'b1; step(6);
        chk("R5 count", got_t.size(), 4);
        exp_ev("R5 first", 0, 1, 'h777, 'h001, -1);
        exp_ev("R5 page ewr", 1, 5, 'h777, 'h002, -1);
        exp_ev("R5 page read", 2, 4, 'h777, 'h003, -1);
        exp_ev("R5 page rmw", 3, 6, 'h777, 'h003, -1);

        // R6 row-only refresh with R1 latency
        clear_ev();
        addr = 13'h1ABC; ras_n = 1'b0; step(6);
        chk("R12 row-only no drive", int'(dq_oe), 0);
        ras_n = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk("R1 not before third edge", int'(cyc_valid), 0);
        @(posedge clk); #1;
        chk("R1 valid at third edge", int'(cyc_valid), 1);
        chk("R6 type", int'(cyc_type), 7);
        chk("R6 ref from row", int'(ref_row), 'hABC);
        @(posedge clk); #1;
        chk("R1 one-clock pulse", int'(cyc_valid), 0);
        step(5);

        // R7 counter refresh
        clear_ev();
        we_n = 1'b1; cas_n = 1'b0; step(3); ras_n = 1'b0; step(6);
        chk("R12 refresh no drive", int'(dq_oe), 0);
        ras_n = 1'b1; step(1); cas_n = 1'b1; step(4);
        cbr_quick(1'b0);
        step(4);
        chk("R7 count", got_t.size(), 2);
        exp_ev("R7 first", 0, 8, -1, -1, 0);
        exp_ev("R7 second", 1, 8, -1, -1, 1);

        // R8 test-mode entry, counter held
        clear_ev();
        cbr_quick(1'b1);
        cbr_quick(1'b0);
        step(4);
        chk("R8 count", got_t.size(), 2);
        exp_ev("R8", 0, 11, -1, -1, -1);
        exp_ev("R8 counter unchanged", 1, 8, -1, -1, 2);

        // R9 hidden refresh
        clear_ev();
        addr = 13'h0444; ras_n = 1'b0; step(4);
        addr = 13'h0055; cas_n = 1'b0; step(5);
        ras_n = 1'b1; step(4);
        ras_n = 1'b0; step(6);
        chk("R9 data kept", int'(dq_oe), 1);
        ras_n = 1'b1; step(3); cas_n = 1'b1; step(6);
        chk("R9 released", int'(dq_oe), 0);
        chk("R9 count", got_t.size(), 2);
        exp_ev("R9 access", 0, 1, 'h444, 'h055, -1);
        exp_ev("R9", 1, 9, -1, -1, 3);

        // R11 simultaneous fall
        clear_ev();
        addr = 13'h0321; ras_n = 1'b0; cas_n = 1'b0; step(6);
        cas_n = 1'b1; ras_n = 1'b1; step(6);
        cbr_quick(1'b0);
        step(4);
        chk("R11 count", got_t.size(), 2);
        exp_ev("R11 access not refresh", 0, 1, 'h321, -1, -1);
        exp_ev("R11 counter unchanged", 1, 8, -1, -1, 4);

        // R10 self-refresh
        clear_ev();
        cas_n = 1'b0; step(3); ras_n = 1'b0; step(SELF_CYC + 30);
        chk("R12 self no drive", int'(dq_oe), 0);
        ras_n = 1'b1; step(1); cas_n = 1'b1; step(6);
        chk("R10 count", got_t.size(), 2);
        exp_ev("R10 entry", 0, 8, -1, -1, 5);
        exp_ev("R10", 1, 10, -1, -1, -1);

        // R7 wrap of the counter
        clear_ev();
        for (int i = 0; i <= NROWS; i++) cbr_quick(1'b0);
        step(4);
        chk("R7 wrap count", got_t.size(), NROWS + 1);
        if (got_ref.size() == NROWS + 1) begin
            chk("R7 wraps", got_ref[NROWS], got_ref[0]);
            chk("R7 before wrap", got_ref[NROWS-1], (got_ref[0] + NROWS - 1) % NROWS);
        end

        chk("R13 code zero when idle", idle_bad, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule